// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs one external memory access at a time across eight address areas and decides how many bus states each access lasts. An accepted request names an area, a read/write flag and an access kind: processor, dual-address DMA or single-address DMA. Per-area enable bits select whether an access may be stretched. A shared two-bit long-wait setting and the active-low `wait_n` input add further states. During the access the block holds a bus-active strobe and the chip select of the addressed area. It pulses `done` in the last state.

Areas 0, 2 and 6 can take programmed long waits. Areas 1, 3, 4, 5 and 7 can be stretched only from the pin. Area 3 never honours the pin, because that pin is shared with another area's select. Processor writes and dual-address DMA writes take their enable from `wr_wait_en`. Every other access takes its enable from `rd_wait_en`. `wait_n` is taken to be synchronous to `clk`. The configuration inputs are held steady while an access runs.

Top module: `ext_wait_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `bus_active`, `chip_sel` and `done` are all 0.
- R2: An access to area 1, 3, 4, 5 or 7 whose enable bit is clear lasts exactly one state, whatever `wait_n` does.
- R3: An access to area 1, 4, 5 or 7 whose enable bit is set lasts two states plus one extra state for each consecutive low `wait_n` sample. The first sample is taken at the clock edge that ends the first state. Sampling repeats at each following edge until `wait_n` reads high, and then the final state follows.
- R4: An access to area 0, 2 or 6 whose enable bit is clear lasts 1 + (`long_wait` + 1) states, whatever `wait_n` does.
- R5: An access to area 0, 2 or 6 whose enable bit is set lasts 1 + (`long_wait` + 1) states plus one state for each consecutive low `wait_n` sample. The first sample is taken at the edge that ends the state before the last long-wait state.
- R6: An access to area 3 whose enable bit is set lasts exactly two states, whatever `wait_n` does.
- R7: `req_kind` encodes 0 = processor, 1 = dual-address DMA, 2 = single-address DMA, and 3 behaves as processor. A write of kind 0, 1 or 3 takes its enable from `wr_wait_en[area]`, and `rd_wait_en` has no effect on it. Every other access takes its enable from `rd_wait_en[area]`, and `wr_wait_en` has no effect on it.
- R8: In every state of an access, including all wait states, `chip_sel` is the one-hot bit of the accessed area. In the cycle after `done`, and in every idle cycle, `chip_sel` is 0 and `bus_active` is 0.
- R9: `done` is high for exactly one cycle, in the final state of an access, and never while idle. A request raised while an access is running is ignored and starts no access.
- R10: A request seen at a clock edge while idle starts the access, and `bus_active` is high from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request; taken only while idle |
| req_area | input | 3 | Area number of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 0 processor, 1 dual-address DMA, 2 single-address DMA, 3 as processor |
| rd_wait_en | input | 8 | Per-area enable for reads and single-address DMA |
| wr_wait_en | input | 8 | Per-area enable for processor and dual-address DMA writes |
| long_wait | input | 2 | Long-wait setting; adds value + 1 states in areas 0, 2, 6 |
| wait_n | input | 1 | Active-low external wait, synchronous to clk |
| bus_active | output | 1 | High in every state of an access |
| chip_sel | output | 8 | One-hot select of the accessed area, active high |
| done | output | 1 | One-cycle pulse in the final state |

## Verification
The hardest case is a pin-stretched access where `wait_n` changes state exactly around the sampling edge. In a long-wait area that edge sits deep inside the access and moves with `long_wait`. So the bench drives `wait_n` from the state number of the running access, holding it low through a chosen state and high afterwards. Sweeping that last-low state past both sides of the sampling edge, for several `long_wait` values, shows whether the controller samples at the right edge and counts consecutive lows. A request raised in mid-access, paired with a per-state chip-select check, shows that a second access cannot begin early.

// File: rtl/ext_wait_pkg.sv
// Shared constants and types of the external-bus wait-state controller.
// Assumes: eight areas and a two-bit long-wait setting by default.
package ext_wait_pkg;

    localparam int unsigned EW_AREAS = 8;
    localparam int unsigned EW_LW_W  = 2;

    typedef enum logic [1:0] {
        KIND_CPU        = 2'b00,
        KIND_DMA_DUAL   = 2'b01,
        KIND_DMA_SINGLE = 2'b10,
        KIND_RSVD       = 2'b11
    } acc_kind_e;

    // True when the access takes its enable from the write-side register.
    function automatic logic is_write_class(input logic write, input logic [1:0] kind);
        return write && (kind != KIND_DMA_SINGLE);
    endfunction

endpackage

// File: rtl/ext_wait_classify.sv
// Works out, from one request and the configuration, how long the access
// runs without pin waits and whether wait_n may stretch it.
// Assumes: inputs are stable in the cycle the request is accepted.
module ext_wait_classify
    import ext_wait_pkg::*;
#(
    parameter int unsigned AREAS = EW_AREAS,
    parameter int unsigned LW_W  = EW_LW_W,
    parameter logic [AREAS-1:0] LONG_MASK  = 8'b0100_0101,
    parameter logic [AREAS-1:0] NOPIN_MASK = 8'b0000_1000,
    localparam int unsigned AREA_W = $clog2(AREAS),
    localparam int unsigned LEN_W  = $clog2((2 ** LW_W) + 3)
) (
    input  logic [AREA_W-1:0] area,
    input  logic              write,
    input  logic [1:0]        kind,
    input  logic [AREAS-1:0]  rd_en,
    input  logic [AREAS-1:0]  wr_en,
    input  logic [LW_W-1:0]   long_wait,
    output logic [LEN_W-1:0]  base_len,
    output logic              pin_wait
);

    logic enable;

    // Select the enable bit from the register that governs this access kind.
    always_comb begin
        enable = is_write_class(write, kind) ? wr_en[area] : rd_en[area];
    end

    // Base length and pin-wait permission per area group.
    always_comb begin
        if (LONG_MASK[area]) begin
            base_len = LEN_W'(long_wait) + LEN_W'(2);
            pin_wait = enable;
        end else begin
            base_len = enable ? LEN_W'(2) : LEN_W'(1);
            pin_wait = enable && !NOPIN_MASK[area];
        end
    end

endmodule

// File: rtl/ext_wait_sequencer.sv
// Counts the states of one access, holding before the final state while
// wait_n reads low, and flags the final state.
// Assumes: base_len >= 2 whenever pin_wait is set; start only while idle.
module ext_wait_sequencer #(
    parameter int unsigned LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] base_len,
    input  logic             pin_wait,
    input  logic             wait_n,
    output logic             active,
    output logic             last
);

    logic [LEN_W-1:0] remain;
    logic             pin_q;
    logic             hold;

    // Stretch only at the edge entering the final state, while wait_n is low.
    always_comb begin
        hold = pin_q && (remain == LEN_W'(1)) && !wait_n;
    end

    // State counter: load on start, count down, stop after the final state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            remain <= '0;
            pin_q  <= 1'b0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                remain <= base_len - LEN_W'(1);
                pin_q  <= pin_wait;
            end
        end else if (remain == '0) begin
            active <= 1'b0;
        end else if (!hold) begin
            remain <= remain - LEN_W'(1);
        end
    end

    assign last = active && (remain == '0);

endmodule

// File: rtl/ext_wait_select.sv
// Captures the area of an accepted request and drives its chip select
// for as long as the access is active.
// Assumes: load is high only in the acceptance cycle.
module ext_wait_select #(
    parameter int unsigned AREAS = 8,
    localparam int unsigned AREA_W = $clog2(AREAS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AREA_W-1:0] area,
    input  logic              active,
    output logic [AREAS-1:0]  chip_sel
);

    logic [AREA_W-1:0] area_q;

    // Area register, written when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            area_q <= '0;
        end else if (load) begin
            area_q <= area;
        end
    end

    // One decoder bit per area, gated by the active strobe.
    for (genvar i = 0; i < AREAS; i++) begin : g_cs
        assign chip_sel[i] = active && (area_q == AREA_W'(i));
    end

endmodule

// File: rtl/ext_wait_ctrl.sv
// Top of the external-bus wait-state controller: accepts one request while
// idle, then runs the access with programmed and pin-requested wait states.
// Assumes: wait_n synchronous to clk; configuration steady during an access.
module ext_wait_ctrl
    import ext_wait_pkg::*;
#(
    parameter int unsigned AREAS = EW_AREAS,
    parameter int unsigned LW_W  = EW_LW_W,
    parameter logic [AREAS-1:0] LONG_MASK  = 8'b0100_0101,
    parameter logic [AREAS-1:0] NOPIN_MASK = 8'b0000_1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [$clog2(AREAS)-1:0] req_area,
    input  logic                     req_write,
    input  logic [1:0]               req_kind,
    input  logic [AREAS-1:0]         rd_wait_en,
    input  logic [AREAS-1:0]         wr_wait_en,
    input  logic [LW_W-1:0]          long_wait,
    input  logic                     wait_n,
    output logic                     bus_active,
    output logic [AREAS-1:0]         chip_sel,
    output logic                     done
);

    localparam int unsigned LEN_W = $clog2((2 ** LW_W) + 3);

    logic             start;
    logic [LEN_W-1:0] base_len;
    logic             pin_wait;

    // Acceptance: a request counts only while no access runs.
    always_comb begin
        start = req_valid && !bus_active;
    end

    ext_wait_classify #(
        .AREAS      (AREAS),
        .LW_W       (LW_W),
        .LONG_MASK  (LONG_MASK),
        .NOPIN_MASK (NOPIN_MASK)
    ) u_classify (
        .area      (req_area),
        .write     (req_write),
        .kind      (req_kind),
        .rd_en     (rd_wait_en),
        .wr_en     (wr_wait_en),
        .long_wait (long_wait),
        .base_len  (base_len),
        .pin_wait  (pin_wait)
    );

    ext_wait_sequencer #(
        .LEN_W (LEN_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .base_len (base_len),
        .pin_wait (pin_wait),
        .wait_n   (wait_n),
        .active   (bus_active),
        .last     (done)
    );

    ext_wait_select #(
        .AREAS (AREAS)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .area     (req_area),
        .active   (bus_active),
        .chip_sel (chip_sel)
    );

endmodule

// File: rtl/ext_wait_ctrl_chk.sv
// Protocol checker for ext_wait_ctrl, attached by bind.
// Assumes: same parameters as the bound instance.
module ext_wait_ctrl_chk
    import ext_wait_pkg::*;
#(
    parameter int unsigned AREAS = EW_AREAS,
    parameter logic [AREAS-1:0] LONG_MASK  = 8'b0100_0101,
    parameter logic [AREAS-1:0] NOPIN_MASK = 8'b0000_1000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [$clog2(AREAS)-1:0] req_area,
    input logic                     req_write,
    input logic [1:0]               req_kind,
    input logic [AREAS-1:0]         rd_wait_en,
    input logic [AREAS-1:0]         wr_wait_en,
    input logic                     bus_active,
    input logic [AREAS-1:0]         chip_sel,
    input logic                     done
);

    logic accept;
    logic en_now;

    always_comb begin
        accept = req_valid && !bus_active;
        en_now = is_write_class(req_write, req_kind) ? wr_wait_en[req_area]
                                                     : rd_wait_en[req_area];
    end

    // R1: reset leaves the bus quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!bus_active && chip_sel == '0 && !done));

    // R2: short area, enable clear, finishes in its first state
    p_short_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !LONG_MASK[req_area] && !en_now) |=> (bus_active && done));

    // R4: long-wait area always lasts at least two states
    p_long_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && LONG_MASK[req_area]) |=> (bus_active && !done));

    // R6: area without pin wait, enabled, lasts exactly two states
    p_nopin_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && NOPIN_MASK[req_area] && !LONG_MASK[req_area] && en_now)
        |=> !done ##1 done);

    // R8: chip select holds steady through every non-final state
    p_cs_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && !done) |=> $stable(chip_sel));

    // R8: one select exactly while active
    p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |-> $onehot(chip_sel));

    // R9: done is a single-cycle pulse followed by idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !bus_active && chip_sel == '0));

    // R9: done never while idle
    p_done_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bus_active);

    // R10: idle request starts the access on the next cycle
    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bus_active);

endmodule

bind ext_wait_ctrl ext_wait_ctrl_chk #(
    .AREAS      (AREAS),
    .LONG_MASK  (LONG_MASK),
    .NOPIN_MASK (NOPIN_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_area   (req_area),
    .req_write  (req_write),
    .req_kind   (req_kind),
    .rd_wait_en (rd_wait_en),
    .wr_wait_en (wr_wait_en),
    .bus_active (bus_active),
    .chip_sel   (chip_sel),
    .done       (done)
);

// File: tb/tb_ext_wait_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected length and area of each
// access, the monitor measures the states and compares at done.
module tb_ext_wait_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_area = '0;
    logic       req_write = 1'b0;
    logic [1:0] req_kind = '0;
    logic [7:0] rd_wait_en = '0;
    logic [7:0] wr_wait_en = '0;
    logic [1:0] long_wait = '0;
    logic       wait_n = 1'b1;
    logic       bus_active;
    logic [7:0] chip_sel;
    logic       done;

    int checks = 0;
    int errors = 0;
    int low_until = 0;
    int state_idx = 0;
    int issued = 0;
    int finished = 0;
    bit prev_done = 1'b0;
    bit over = 1'b0;

    int    q_len[$];
    int    q_area[$];
    string q_tag[$];

    always #4 clk = ~clk;

    ext_wait_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_area(req_area),
        .req_write(req_write), .req_kind(req_kind), .rd_wait_en(rd_wait_en),
        .wr_wait_en(wr_wait_en), .long_wait(long_wait), .wait_n(wait_n),
        .bus_active(bus_active), .chip_sel(chip_sel), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected state count from the requirements.
    function automatic int exp_len(input int area, input bit wr, input int kind, input int low);
        bit wclass, en, pin;
        int base, n;
        wclass = wr && (kind != 2);
        en = wclass ? wr_wait_en[area] : rd_wait_en[area];
        if (area == 0 || area == 2 || area == 6) begin
            base = 2 + int'(long_wait);
            pin = en;
        end else begin
            base = en ? 2 : 1;
            pin = en && (area != 3);
        end
        n = (pin && low >= base - 1) ? low - base + 2 : 0;
        return base + n;
    endfunction

    // Driver: queue the expectation, raise one request, optionally poke a busy request.
    task automatic run_access(input string tag, input int area, input bit wr,
                              input int kind, input int low, input bit poke);
        @(negedge clk);
        while (bus_active) @(negedge clk);
        low_until = low;
        q_len.push_back(exp_len(area, wr, kind, low));
        q_area.push_back(area);
        q_tag.push_back(tag);
        issued++;
        req_area = 3'(area);
        req_write = wr;
        req_kind = 2'(kind);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_active == 1'b1, {tag, " R10 start"}, int'(bus_active), 1);
        if (poke) begin
            req_area = 3'((area + 1) % 8);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (q_len.size() != 0) @(negedge clk);
    endtask

    // Monitor: per-state chip-select checks, length compare at done, wait_n by state number.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done)
                chk(!bus_active && chip_sel == 8'h00, "R8 idle after done",
                    int'(chip_sel), 0);
            if (bus_active) begin
                state_idx++;
                if (q_len.size() == 0) begin
                    chk(1'b0, "R9 unexpected access", int'(chip_sel), 0);
                end else begin
                    chk(chip_sel == (8'h01 << q_area[0]), {q_tag[0], " R8 chip_sel"},
                        int'(chip_sel), int'(8'h01 << q_area[0]));
                end
                wait_n = !(state_idx <= low_until);
                if (done) begin
                    if (q_len.size() != 0) begin
                        chk(state_idx == q_len[0], {q_tag[0], " length"}, state_idx, q_len[0]);
                        void'(q_len.pop_front());
                        void'(q_area.pop_front());
                        void'(q_tag.pop_front());
                    end
                    finished++;
                    state_idx = 0;
                end
            end else begin
                chk(!done && chip_sel == 8'h00, "R9 idle quiet", int'(done), 0);
                wait_n = 1'b0;
            end
            prev_done = done;
        end
    end

    task automatic finish_run();
        if (!over) begin
            over = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(!bus_active && chip_sel == 8'h00 && !done, "R1 in reset", int'(bus_active), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_active && chip_sel == 8'h00 && !done, "R1 after reset", int'(chip_sel), 0);

        // R2: short areas, enable clear, wait_n held low
        run_access("R2 a1 cpu rd", 1, 0, 0, 50, 0);
        run_access("R2 a5 dual rd", 5, 0, 1, 50, 0);
        run_access("R2 a3 cpu rd", 3, 0, 0, 50, 0);
        wr_wait_en = 8'h80;
        run_access("R7 a7 single wr uses rd reg", 7, 1, 2, 50, 0);

        // R3: short areas enabled, sweep the last-low state
        rd_wait_en = 8'b1011_0010;
        wr_wait_en = 8'h00;
        run_access("R3 a1 no low", 1, 0, 0, 0, 0);
        run_access("R3 a1 low s1", 1, 0, 0, 1, 0);
        run_access("R3 a4 low s3", 4, 0, 1, 3, 0);
        run_access("R3 a7 single wr low s2", 7, 1, 2, 2, 0);

        // R6: area 3 enabled ignores wait_n
        rd_wait_en = 8'b0000_1000;
        run_access("R6 a3 enabled", 3, 0, 0, 50, 0);

        // R4: long group, enable clear
        rd_wait_en = 8'h00;
        long_wait = 2'd0;
        run_access("R4 a0 lw0", 0, 0, 0, 50, 0);
        long_wait = 2'd3;
        run_access("R4 a6 lw3", 6, 0, 1, 50, 0);

        // R5: long group enabled, sampling edge moves with long_wait
        rd_wait_en = 8'b0100_0101;
        long_wait = 2'd1;
        run_access("R5 a2 lw1 no low", 2, 0, 0, 0, 0);
        run_access("R5 a2 lw1 low s1", 2, 0, 0, 1, 0);
        run_access("R5 a2 lw1 low s4", 2, 0, 0, 4, 0);
        long_wait = 2'd3;
        run_access("R5 a6 lw3 low s4", 6, 0, 2, 4, 0);
        run_access("R5 a0 lw3 low s3", 0, 0, 0, 3, 0);

        // R7: writes use the write-side register only
        long_wait = 2'd0;
        rd_wait_en = 8'h20;
        wr_wait_en = 8'h00;
        run_access("R7 a5 cpu wr rd-set", 5, 1, 0, 50, 0);
        rd_wait_en = 8'h00;
        wr_wait_en = 8'h21;
        run_access("R7 a5 cpu wr wr-set", 5, 1, 0, 2, 0);
        run_access("R7 a0 dual wr wr-set", 0, 1, 1, 1, 0);
        run_access("R7 a5 cpu rd wr-set", 5, 0, 0, 50, 0);

        // R9: requests during an access are ignored
        rd_wait_en = 8'h00;
        long_wait = 2'd3;
        run_access("R9 poke long", 2, 0, 0, 0, 1);
        run_access("R9 poke short", 4, 0, 0, 0, 1);

        repeat (4) @(negedge clk);
        chk(finished == issued, "R9 access count", finished, issued);
        chk(q_len.size() == 0, "R9 queue drained", q_len.size(), 0);
        finish_run();
    end

endmodule